// File: doc/BRIEF.md
# Pseudo-SRAM Page-Mode Controller

This block sits between a synchronous host and an asynchronous pseudo-static RAM. The RAM has a 19-bit word address and a 16-bit data path. Each request is a word read, a word or byte-masked write, or a multi-word page read. The host offers it on a valid/ready handshake. The controller then drives chip select, output enable, write enable, the two byte-lane strobes and the low-power pin. It times each strobe phase in whole system-clock cycles, derived at elaboration from the clock frequency and nanosecond parameters. It returns each read word to the host with a one-cycle valid pulse.

After reset the controller waits for the supply-good input. It then keeps the memory deselected for a parameterised number of microseconds before it accepts any work. A page read holds the upper address bits and steps the low bits inside a page of 8 or 16 words. The first word takes a full random-access time and each later word takes the shorter page time. A sequence that reaches the end of a page drops chip select for one cycle and continues with a fresh random access. Page stepping can be turned off with `PAGE_WORDS = 0`. The low-power pin can be enabled with `HAS_DEEP_PD`.

The state machine has these states:

| State | Meaning |
|---|---|
| `ST_PWRUP` | Power-up lockout |
| `ST_IDLE` | Ready for a request |
| `ST_RD_RAND` | Full random read |
| `ST_RD_PAGE` | Intra-page read |
| `ST_WR_PULSE` | Write-enable low |
| `ST_RECOVER` | One deselected cycle |
| `ST_SLEEP` | Low-power pin asserted |

The transitions are:

- `ST_PWRUP`→`ST_IDLE` when the lockout expires.
- `ST_IDLE`→`ST_WR_PULSE` on an accepted write.
- `ST_IDLE`→`ST_RD_RAND` on an accepted read or page read.
- `ST_IDLE`→`ST_SLEEP` on a low-power request.
- `ST_RD_RAND`/`ST_RD_PAGE`→`ST_RD_PAGE` when more words remain and the current word is not last in its page.
- `ST_RD_RAND`/`ST_RD_PAGE`→`ST_RECOVER` when the sequence is done or the page ends.
- `ST_WR_PULSE`→`ST_RECOVER` at the end of the pulse.
- `ST_SLEEP`→`ST_RECOVER` when the request drops.
- `ST_RECOVER`→`ST_RD_RAND` when words remain.
- `ST_RECOVER`→`ST_IDLE` otherwise.

Top module: `psram_page_ctrl`

## Requirements
- R1: **Power-up hold.** After reset, `mem_cs_n` stays high and `req_ready` stays low while `supply_good` is low. Once `supply_good` goes high, `req_ready` first rises exactly PU_CYC+1 cycles later, where PU_CYC = PWRUP_US × CLK_MHZ.
- R2: **Random read.** A read (`req_op` = 0) holds the address with `mem_cs_n` and `mem_oe_n` low for RC_CYC cycles. RC_CYC is T_RC_NS × CLK_MHZ / 1000, rounded up. The read then returns the addressed word with exactly one `rd_valid` pulse.
- R3: **Word write.** A write (`req_op` = 1) drives `mem_we_n` low for exactly WP_CYC cycles. During that time `mem_cs_n` is low and `mem_oe_n` is high.
- R4: **Byte-lane masking.** `req_be[0]` selects the lower byte lane through `mem_lb_n` (low = written). `req_be[1]` selects the upper lane through `mem_ub_n`. An unselected lane keeps its old content.
- R5: **Page read.** A page read (`req_op` = 2) returns `req_len` consecutive words in address order, one `rd_valid` pulse each. The upper address bits above the page offset stay fixed while chip select is low. The first word of a run is held RC_CYC cycles and each following word PC_CYC cycles.
- R6: **Page-boundary split.** When the next word lies in a new page (its offset is zero), chip select goes high for one cycle. That word then starts a new random access of RC_CYC cycles.
- R7: **Page mode off.** With `PAGE_WORDS` = 0, every word of a page read gets its own chip-select pulse, so the number of `mem_cs_n` falling edges equals the word count.
- R8: **Data-bus ownership.** `mem_dq_oe` is high only while `mem_we_n` is low and `mem_oe_n` is high. It has been low for at least one cycle before `mem_oe_n` falls.
- R9: **Handshake.** `req_ready` is high only in the idle state, and the memory is deselected while it is high. A page read with `req_len` = 0 returns one word.
- R10: **Low-power pin.** With `HAS_DEEP_PD` = 1, holding `lp_req` high while idle drives `mem_zz_n` low, keeps `mem_cs_n` high and drops `req_ready` until `lp_req` falls. With `HAS_DEEP_PD` = 0, `mem_zz_n` stays high and `lp_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_good | input | 1 | Memory supply has reached its operating level |
| lp_req | input | 1 | Request low-power mode while idle |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 page read |
| req_addr | input | ADDR_W | Word address (start address for page reads) |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Byte enables: bit 0 lower, bit 1 upper |
| req_len | input | LEN_W | Page-read word count (0 treated as 1) |
| rd_valid | output | 1 | One pulse per returned read word |
| rd_data | output | DATA_W | Returned read word |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_zz_n | output | 1 | Low-power control, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |
| mem_dq_i | input | DATA_W | Data returned by the memory |

## Verification
The bench times every address hold, so a page read that crossed a page without deselecting, or gave a post-boundary word only the short page time, shows up as a wrong run length. Two byte-masked writes to one word, followed by a read, catch swapped or ignored lane strobes. A second instance, with page mode off and no power-down pin, must pulse chip select once per word and ignore `lp_req`. The exact lockout cycle count exposes an off-by-one in the power-up hold.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PAGE  = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_RD_RAND,
        ST_RD_PAGE,
        ST_WR_PULSE,
        ST_RECOVER,
        ST_SLEEP
    } state_e;

    // Convert nanoseconds to whole clock cycles, rounding up, minimum one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/psram_pwrup_timer.sv
module psram_pwrup_timer #(
    parameter int unsigned HOLD_CYC = 50000,
    localparam int unsigned CW = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good,
    output logic done
);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (!supply_good) begin
                cnt_q <= '0;
            end else begin
                if (cnt_q == CW'(HOLD_CYC - 1)) begin
                    done_q <= 1'b1;
                end
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/psram_cycle_timer.sv
module psram_cycle_timer #(
    parameter int unsigned TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_addr_step.sv
module psram_addr_step #(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned PAGE_BITS = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_next,
    output logic              last_in_page
);

    assign addr_next = addr_i + 1'b1;

    generate
        if (PAGE_BITS == 0) begin : g_nopage
            assign last_in_page = 1'b1;
        end else begin : g_page
            assign last_in_page = &addr_i[PAGE_BITS-1:0];
        end
    endgenerate

endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned LEN_W       = 5,
    parameter int unsigned CLK_MHZ     = 250,
    parameter int unsigned T_RC_NS     = 70,
    parameter int unsigned T_PC_NS     = 25,
    parameter int unsigned T_WP_NS     = 55,
    parameter int unsigned PWRUP_US    = 200,
    parameter int unsigned PAGE_WORDS  = 8,
    parameter bit          HAS_DEEP_PD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_good,
    input  logic              lp_req,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic              mem_zz_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned RC_CYC    = ns_to_cyc(T_RC_NS, CLK_MHZ);
    localparam int unsigned PC_CYC    = ns_to_cyc(T_PC_NS, CLK_MHZ);
    localparam int unsigned WP_CYC    = ns_to_cyc(T_WP_NS, CLK_MHZ);
    localparam int unsigned PU_CYC    = PWRUP_US * CLK_MHZ;
    localparam int unsigned MAX_CYC   = (RC_CYC > WP_CYC) ? RC_CYC : WP_CYC;
    localparam int unsigned TW        = $clog2(MAX_CYC + 1);
    localparam int unsigned PAGE_BITS = (PAGE_WORDS == 16) ? 4 : (PAGE_WORDS == 8) ? 3 : 0;

    state_e state_q, state_d;

    logic              pu_done;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_done;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;
    logic              last_in_page;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        be_q;
    logic [LEN_W-1:0]  left_q;
    logic              accept;
    logic              sleep_go;
    logic              rd_state;
    logic              capture;

    psram_pwrup_timer #(.HOLD_CYC(PU_CYC)) u_pwrup (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_good (supply_good),
        .done        (pu_done)
    );

    psram_cycle_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_addr_step #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_step (
        .addr_i       (addr_q),
        .addr_next    (addr_next),
        .last_in_page (last_in_page)
    );

    assign sleep_go = HAS_DEEP_PD && lp_req;
    assign accept   = req_valid && req_ready;
    assign rd_state = (state_q == ST_RD_RAND) || (state_q == ST_RD_PAGE);
    assign capture  = rd_state && tmr_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and cycle-timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PWRUP: begin
                if (pu_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_op == OP_WRITE) begin
                        state_d = ST_WR_PULSE;
                        tmr_val = TW'(WP_CYC - 1);
                    end else begin
                        state_d = ST_RD_RAND;
                        tmr_val = TW'(RC_CYC - 1);
                    end
                end else if (sleep_go) begin
                    state_d = ST_SLEEP;
                end
            end
            ST_RD_RAND, ST_RD_PAGE: begin
                if (tmr_done) begin
                    if (left_q > LEN_W'(1) && !last_in_page) begin
                        state_d  = ST_RD_PAGE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(PC_CYC - 1);
                    end else begin
                        state_d = ST_RECOVER;
                    end
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (left_q != '0) begin
                    state_d  = ST_RD_RAND;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RC_CYC - 1);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SLEEP: begin
                if (!lp_req) state_d = ST_RECOVER;
            end
            default: state_d = ST_PWRUP;
        endcase
    end

    // Request datapath and read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            left_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                if (req_op == OP_WRITE) begin
                    be_q   <= req_be;
                    left_q <= '0;
                end else begin
                    be_q <= 2'b11;
                    if (req_op == OP_PAGE && req_len != '0) begin
                        left_q <= req_len;
                    end else begin
                        left_q <= LEN_W'(1);
                    end
                end
            end else if (capture) begin
                rd_data  <= mem_dq_i;
                rd_valid <= 1'b1;
                left_q   <= left_q - 1'b1;
                if (left_q > LEN_W'(1)) begin
                    addr_q <= addr_next;
                end
            end
        end
    end

    // Strobe and handshake outputs
    always_comb begin
        req_ready = 1'b0;
        mem_cs_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_ub_n  = 1'b1;
        mem_lb_n  = 1'b1;
        mem_zz_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = !sleep_go;
            end
            ST_RD_RAND, ST_RD_PAGE: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_ub_n = 1'b0;
                mem_lb_n = 1'b0;
            end
            ST_WR_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_ub_n  = !be_q[1];
                mem_lb_n  = !be_q[0];
                mem_dq_oe = 1'b1;
            end
            ST_SLEEP: begin
                mem_zz_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;

endmodule

// File: rtl/psram_page_ctrl_chk.sv
module psram_page_ctrl_chk #(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned PAGE_BITS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pu_done,
    input logic              req_ready,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_zz_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1
    pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_done |-> (mem_cs_n && !req_ready));

    // R3
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    // R8
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n));

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R5
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr[ADDR_W-1:PAGE_BITS]));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n);

    // R10
    zz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_zz_n |-> (mem_cs_n && !req_ready));

endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pu_done   (pu_done),
    .req_ready (req_ready),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_zz_n  (mem_zz_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/psram_page_ctrl_tb.sv
module psram_mem_model (
    input  logic        clk,
    input  logic [18:0] addr,
    input  logic        cs_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        ub_n,
    input  logic        lb_n,
    input  logic [15:0] dq_o,
    input  logic        dq_oe,
    output logic [15:0] dq_i
);
    logic [15:0] mem [0:255];
    initial for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0103 + 16'h0042);
    always @(posedge clk) begin
        if (!cs_n && !we_n && dq_oe) begin
            if (!lb_n) mem[addr[7:0]][7:0]  <= dq_o[7:0];
            if (!ub_n) mem[addr[7:0]][15:8] <= dq_o[15:8];
        end
    end
    assign dq_i = (!cs_n && !oe_n) ? mem[addr[7:0]] : 16'h0000;
endmodule

module psram_page_ctrl_tb;
    localparam int RC = 18, PC = 7, WP = 14, PU = 500;
    localparam int NV = 10;
    // op[43:42] addr[41:23] wdata[22:7] be[6:5] len[4:0]
    localparam logic [43:0] VEC [NV] = '{
        {2'd1, 19'd5,  16'h1234, 2'b11, 5'd0},
        {2'd1, 19'd5,  16'hAB00, 2'b10, 5'd0},
        {2'd1, 19'd6,  16'h00CD, 2'b01, 5'd0},
        {2'd0, 19'd5,  16'h0000, 2'b00, 5'd0},
        {2'd0, 19'd6,  16'h0000, 2'b00, 5'd0},
        {2'd2, 19'd16, 16'h0000, 2'b00, 5'd3},
        {2'd2, 19'd6,  16'h0000, 2'b00, 5'd4},
        {2'd2, 19'd30, 16'h0000, 2'b00, 5'd0},
        {2'd1, 19'd40, 16'hBEEF, 2'b11, 5'd0},
        {2'd2, 19'd39, 16'h0000, 2'b00, 5'd2}
    };

    logic clk = 1'b0, rst_n = 1'b0, supply_good = 1'b0, lp_req = 1'b0, req_valid = 1'b0;
    logic [1:0] req_op = '0, req_be = '0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [4:0] req_len = '0;

    logic ready1, rv1, cs1, oe1, we1, ub1, lb1, zz1, dqoe1;
    logic [15:0] rd1, dqo1, dqi1;
    logic [18:0] a1;
    logic ready2, rv2, cs2, oe2, we2, ub2, lb2, zz2, dqoe2;
    logic [15:0] rd2, dqo2, dqi2;
    logic [18:0] a2;

    always #2 clk = ~clk;

    psram_page_ctrl #(.CLK_MHZ(250), .PWRUP_US(2), .PAGE_WORDS(8), .HAS_DEEP_PD(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .lp_req(lp_req),
        .req_valid(req_valid), .req_ready(ready1), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_len(req_len),
        .rd_valid(rv1), .rd_data(rd1), .mem_addr(a1), .mem_cs_n(cs1), .mem_oe_n(oe1),
        .mem_we_n(we1), .mem_ub_n(ub1), .mem_lb_n(lb1), .mem_zz_n(zz1),
        .mem_dq_o(dqo1), .mem_dq_oe(dqoe1), .mem_dq_i(dqi1));

    psram_page_ctrl #(.CLK_MHZ(250), .PWRUP_US(2), .PAGE_WORDS(0), .HAS_DEEP_PD(1'b0)) u_dut_np (
        .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .lp_req(lp_req),
        .req_valid(req_valid), .req_ready(ready2), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_len(req_len),
        .rd_valid(rv2), .rd_data(rd2), .mem_addr(a2), .mem_cs_n(cs2), .mem_oe_n(oe2),
        .mem_we_n(we2), .mem_ub_n(ub2), .mem_lb_n(lb2), .mem_zz_n(zz2),
        .mem_dq_o(dqo2), .mem_dq_oe(dqoe2), .mem_dq_i(dqi2));

    psram_mem_model u_m1 (.clk(clk), .addr(a1), .cs_n(cs1), .oe_n(oe1), .we_n(we1),
        .ub_n(ub1), .lb_n(lb1), .dq_o(dqo1), .dq_oe(dqoe1), .dq_i(dqi1));
    psram_mem_model u_m2 (.clk(clk), .addr(a2), .cs_n(cs2), .oe_n(oe2), .we_n(we2),
        .ub_n(ub2), .lb_n(lb2), .dq_o(dqo2), .dq_oe(dqoe2), .dq_i(dqi2));

    int n_chk = 0, n_fail = 0;
    logic [15:0] ref_mem [0:255];
    logic [15:0] rx [0:31];
    int runs [0:31];
    int n_rx, n_runs, run_len, we_cnt, last_we, cs2_falls, n_rx2;
    int contention = 0, dq_seen = 0, busy_ready = 0, cs_pre = 0;
    logic in_run = 1'b0, prev_oe1 = 1'b1, prev_dqoe1 = 1'b0, prev_cs2 = 1'b1, seen_lb, seen_ub;
    logic [18:0] run_addr;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_tb();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Port monitors, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs1 && !oe1) begin
                if (in_run && a1 == run_addr) run_len++;
                else begin
                    if (in_run && n_runs < 32) begin runs[n_runs] = run_len; n_runs++; end
                    run_addr = a1; run_len = 1; in_run = 1'b1;
                end
            end else if (in_run) begin
                if (n_runs < 32) begin runs[n_runs] = run_len; n_runs++; end
                in_run = 1'b0;
            end
            if (!we1) begin we_cnt++; seen_lb = !lb1; seen_ub = !ub1; end
            else if (we_cnt != 0) begin last_we = we_cnt; we_cnt = 0; end
            if (dqoe1 && (!oe1 || we1)) contention++;
            if (!oe1 && prev_oe1 && prev_dqoe1) contention++;
            if (dqoe1) dq_seen++;
            if (ready1 && !cs1) busy_ready++;
            if (!pu_seen && !cs1) cs_pre++;
            prev_oe1 = oe1; prev_dqoe1 = dqoe1;
            if (rv1 && n_rx < 32) begin rx[n_rx] = rd1; n_rx++; end
            if (prev_cs2 && !cs2) cs2_falls++;
            prev_cs2 = cs2;
            if (rv2) n_rx2++;
        end
    end

    logic pu_seen = 1'b0;

    task automatic wait_both_ready();
        while (!(ready1 && ready2)) @(negedge clk);
    endtask

    task automatic run_vec(input logic [43:0] v);
        logic [1:0] op; logic [18:0] ad; logic [15:0] wd; logic [1:0] be; logic [4:0] ln;
        int cnt;
        {op, ad, wd, be, ln} = v;
        n_rx = 0; n_runs = 0; we_cnt = 0; last_we = 0; cs2_falls = 0; n_rx2 = 0;
        seen_lb = 1'b0; seen_ub = 1'b0;
        wait_both_ready();
        req_valid = 1'b1; req_op = op; req_addr = ad; req_wdata = wd; req_be = be; req_len = ln;
        @(negedge clk);
        req_valid = 1'b0;
        wait_both_ready();
        repeat (2) @(negedge clk);
        if (op == 2'd1) begin
            if (be[0]) ref_mem[ad[7:0]][7:0]  = wd[7:0];
            if (be[1]) ref_mem[ad[7:0]][15:8] = wd[15:8];
            chk("R3 write pulse cycles", last_we, WP);
            chk("R4 lower strobe", seen_lb, be[0]);
            chk("R4 upper strobe", seen_ub, be[1]);
        end else begin
            cnt = (op == 2'd2) ? ((ln == 0) ? 1 : int'(ln)) : 1;
            chk("R9 word count", n_rx, cnt);
            chk("R7 chip-select pulses without page mode", cs2_falls, cnt);
            chk("R7 word count without page mode", n_rx2, cnt);
            for (int k = 0; k < cnt; k++) begin
                logic [18:0] a;
                a = ad + 19'(k);
                chk((op == 2'd2) ? "R5 page data" : "R2 read data", rx[k], ref_mem[a[7:0]]);
                chk((k != 0 && a[2:0] == 3'd0) ? "R6 split hold" : "R5 hold cycles",
                    runs[k], (k == 0 || a[2:0] == 3'd0) ? RC : PC);
            end
        end
    endtask

    initial begin
        int wait_cnt;
        for (int i = 0; i < 256; i++) ref_mem[i] = 16'(i * 16'h0103 + 16'h0042);
        repeat (5) @(negedge clk);
        chk("R1 reset cs_n", cs1, 1);
        chk("R1 reset ready", ready1, 0);
        chk("R10 reset zz_n", zz1, 1);
        chk("R2 reset rd_valid", rv1, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 ready without supply", ready1, 0);
        supply_good = 1'b1;
        wait_cnt = 0;
        do begin @(negedge clk); wait_cnt++; end while (!ready1 && wait_cnt < 2000);
        pu_seen = 1'b1;
        chk("R1 lockout length", wait_cnt, PU + 1);
        chk("R1 cs held high during lockout", cs_pre, 0);

        for (int v = 0; v < NV; v++) run_vec(VEC[v]);

        chk("R8 bus contention events", contention, 0);
        chk("R8 bus driven during writes", (dq_seen > 0) ? 1 : 0, 1);
        chk("R9 ready while busy", busy_ready, 0);

        // R10 low-power pin
        lp_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 zz_n low", zz1, 0);
        chk("R10 ready low while sleeping", ready1, 0);
        chk("R10 cs_n high while sleeping", cs1, 1);
        chk("R10 zz_n ignored without power-down", zz2, 1);
        chk("R10 ready kept without power-down", ready2, 1);
        lp_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 zz_n released", zz1, 1);
        chk("R10 ready restored", ready1, 1);
        run_vec(VEC[3]);
        finish_tb();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_tb();
    end

endmodule